// File: doc/BRIEF.md
# Move Instruction Decoder with Destination Prefix

This block decodes 16-bit instruction words for a core in which every operation is a single move. The move goes either from an 8-bit immediate or from a source register to a destination register. Arithmetic, logic and branching come from moves to particular register addresses, whose writes have side effects elsewhere. The block splits each word into a source part and a destination part. It marks the source as an immediate or as a module/register pair, and it resolves the destination to a 4-bit module and a 5-bit register index. It then raises a write strobe so that the register banks outside the block can act on the move.

The instruction word has room for only three destination index bits. To reach the upper 24 registers of a module, software first issues a separate prefix move to a reserved module. That prefix supplies the two missing index bits, and it can also supply a high byte for the immediate. The prefix affects only the next valid instruction and then expires, so each prefixed move costs one extra cycle. The core feeds one word per cycle with a valid flag. The decoded result appears one clock later, registered.

Top module: `move_decoder`

## Requirements
- R1: Each valid, non-prefix instruction sampled at a rising edge makes `wrStrobe` high for exactly the following cycle. A cycle with `instrValid` low yields `wrStrobe` low.
- R2: Bit 15 selects the source format: 0 = immediate in bits 7..0, 1 = register. On a strobe, `srcIsImm` is the inverse of bit 15. For an immediate source, `srcModule` and `srcIndex` read 0. For a register source, `immValue` reads 0.
- R3: For a register source, `srcModule` equals bits 3..0 and `srcIndex` equals bits 7..4.
- R4: `dstModule` equals bits 11..8. `dstIndex` is {upper, bits 14..12}, where upper is 2'b00 unless a prefix is pending.
- R5: A valid instruction whose bits 11..8 equal `PFX_MODULE` (default 11) is a prefix. It raises no strobe. It records bits 13..12 as the upper destination index bits, bit 14 as the immediate-byte enable, and bits 7..0 as the prefix byte.
- R6: A pending prefix applies to the next valid instruction only and is then cleared. Cycles with `instrValid` low do not consume it. A newer prefix replaces an older pending one.
- R7: An immediate is zero-extended to 16 bits. When the pending prefix has its byte enable set, the prefix byte instead forms bits 15..8 of `immValue`.
- R8: Synchronous active-high `rst` clears any pending prefix and holds `wrStrobe` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| wrStrobe | output | 1 | Destination write for the decoded move |
| srcIsImm | output | 1 | Source is an immediate |
| srcModule | output | 4 | Source register module |
| srcIndex | output | 4 | Source register index |
| immValue | output | 16 | Immediate value, extended |
| dstModule | output | 4 | Destination module |
| dstIndex | output | 5 | Destination register index |

## Verification
The embedded properties assume that `instr` is a known value whenever `instrValid` is high. They also assume that reset is asserted at the start, before any word is decoded. The bench drives inputs only on falling edges, holds reset for several cycles before the first word, and then sweeps every 16-bit word with a single reference model of the prefix state. Directed prefix sequences then try each prefix setting against varied follow-on words, with idle cycles in between and a reset issued while a prefix is pending.

// File: rtl/move_decoder_pkg.sv
package move_decoder_pkg;
  localparam int INSTR_W  = 16;
  localparam int MOD_W    = 4;
  localparam int SUB_W    = 3;
  localparam int HI_W     = 2;
  localparam int IDX_W    = SUB_W + HI_W;
  localparam int SRCIDX_W = 4;
  localparam int IMM_W    = 8;
  localparam int DATA_W   = 2 * IMM_W;
  localparam int FMT_BIT  = INSTR_W - 1;
  localparam int DMOD_LO  = IMM_W;
  localparam int DSUB_LO  = IMM_W + MOD_W;

  typedef struct packed {
    logic              issue;
    logic              isImm;
    logic              useByte;
    logic [HI_W-1:0]   dstHi;
    logic [IMM_W-1:0]  immHi;
  } decStrobe_t;
endpackage

// File: rtl/move_decoder_ctrl.sv
module move_decoder_ctrl
  import move_decoder_pkg::*;
#(
  parameter logic [MOD_W-1:0] PFX_MODULE = 4'hB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output decStrobe_t         strobes,
  output logic               pfxPending
);
  logic              isPrefix;
  logic [HI_W-1:0]   pfxHi;
  logic              pfxByteEn;
  logic [IMM_W-1:0]  pfxByte;

  assign isPrefix = (instr[DMOD_LO +: MOD_W] == PFX_MODULE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pfxPending <= 1'b0;
      pfxHi      <= '0;
      pfxByteEn  <= 1'b0;
      pfxByte    <= '0;
    end else if (instrValid) begin
      if (isPrefix) begin
        pfxPending <= 1'b1;
        pfxHi      <= instr[DSUB_LO +: HI_W];
        pfxByteEn  <= instr[DSUB_LO + HI_W];
        pfxByte    <= instr[IMM_W-1:0];
      end else begin
        pfxPending <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.issue   = instrValid && !isPrefix;
    strobes.isImm   = !instr[FMT_BIT];
    strobes.useByte = pfxPending && pfxByteEn;
    strobes.dstHi   = pfxPending ? pfxHi : '0;
    strobes.immHi   = pfxByte;
  end

  // R6: a consumed prefix is gone afterwards
  p_pfx_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !isPrefix) |=> !pfxPending);
  // R5: a prefix word leaves a pending prefix
  p_pfx_arms_r5: assert property (@(posedge clk) disable iff (rst)
    (instrValid && isPrefix) |=> pfxPending);
  // R6: idle cycles keep the pending state
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> $stable(pfxPending));
endmodule

// File: rtl/move_decoder_dp.sv
module move_decoder_dp
  import move_decoder_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [INSTR_W-1:0]  instr,
  input  decStrobe_t          strobes,
  output logic                wrStrobe,
  output logic                srcIsImm,
  output logic [MOD_W-1:0]    srcModule,
  output logic [SRCIDX_W-1:0] srcIndex,
  output logic [DATA_W-1:0]   immValue,
  output logic [MOD_W-1:0]    dstModule,
  output logic [IDX_W-1:0]    dstIndex
);
  logic [IMM_W-1:0] immUpper;
  assign immUpper = strobes.useByte ? strobes.immHi : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrStrobe  <= 1'b0;
      srcIsImm  <= 1'b0;
      srcModule <= '0;
      srcIndex  <= '0;
      immValue  <= '0;
      dstModule <= '0;
      dstIndex  <= '0;
    end else begin
      wrStrobe <= strobes.issue;
      if (strobes.issue) begin
        srcIsImm  <= strobes.isImm;
        dstModule <= instr[DMOD_LO +: MOD_W];
        dstIndex  <= {strobes.dstHi, instr[DSUB_LO +: SUB_W]};
        if (strobes.isImm) begin
          immValue  <= {immUpper, instr[IMM_W-1:0]};
          srcModule <= '0;
          srcIndex  <= '0;
        end else begin
          immValue  <= '0;
          srcModule <= instr[MOD_W-1:0];
          srcIndex  <= instr[MOD_W +: SRCIDX_W];
        end
      end
    end
  end

  // R7: without the byte enable an immediate has a clear high byte
  p_imm_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.issue && strobes.isImm && !strobes.useByte) |=> (immValue[DATA_W-1:IMM_W] == '0));
  // R2: a register source reports no immediate
  p_reg_no_imm_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.issue && !strobes.isImm) |=> (immValue == '0 && !srcIsImm));
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import move_decoder_pkg::*;
#(
  parameter logic [3:0] PFX_MODULE = 4'hB
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [15:0] instr,
  output logic        wrStrobe,
  output logic        srcIsImm,
  output logic [3:0]  srcModule,
  output logic [3:0]  srcIndex,
  output logic [15:0] immValue,
  output logic [3:0]  dstModule,
  output logic [4:0]  dstIndex
);
  decStrobe_t strobes;
  logic       pendingW;

  move_decoder_ctrl #(.PFX_MODULE(PFX_MODULE)) u_ctrl (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .strobes(strobes), .pfxPending(pendingW)
  );

  move_decoder_dp u_dp (
    .clk(clk), .rst(rst), .instr(instr), .strobes(strobes),
    .wrStrobe(wrStrobe), .srcIsImm(srcIsImm), .srcModule(srcModule),
    .srcIndex(srcIndex), .immValue(immValue), .dstModule(dstModule),
    .dstIndex(dstIndex)
  );

  // R5: a prefix word never writes
  p_pfx_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (instrValid && instr[11:8] == PFX_MODULE) |=> !wrStrobe);
  // R4: an unprefixed move reaches only the low eight registers
  p_plain_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (instrValid && instr[11:8] != PFX_MODULE && !pendingW) |=> (wrStrobe && dstIndex[4:3] == 2'b00));
  // R4: destination module follows the word
  p_dst_module_r4: assert property (@(posedge clk) disable iff (rst)
    (instrValid && instr[11:8] != PFX_MODULE) |=> (dstModule == $past(instr[11:8])));
  // R1: no word, no write
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> !wrStrobe);
  // R8: reset silences the strobe
  p_reset_quiet_r8: assert property (@(posedge clk) rst |=> !wrStrobe);
endmodule

// File: tb/tb_move_decoder.sv
module tb_move_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PFX = 4'hB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instr = '0;
  logic        wrStrobe, srcIsImm;
  logic [3:0]  srcModule, srcIndex, dstModule;
  logic [15:0] immValue;
  logic [4:0]  dstIndex;

  int checks = 0;
  int errors = 0;

  logic       mPend = 1'b0;
  logic [1:0] mHi = '0;
  logic       mEn = 1'b0;
  logic [7:0] mByte = '0;

  move_decoder #(.PFX_MODULE(PFX)) dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .wrStrobe(wrStrobe), .srcIsImm(srcIsImm), .srcModule(srcModule),
    .srcIndex(srcIndex), .immValue(immValue), .dstModule(dstModule),
    .dstIndex(dstIndex)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic v, input logic [15:0] w);
    logic isP;
    logic [15:0] expImm;
    instrValid = v;
    instr = w;
    isP = (w[11:8] == PFX);
    @(negedge clk);
    if (!v || isP) begin
      check(isP ? "R5 no strobe on prefix" : "R1 idle no strobe", {31'd0, wrStrobe}, 32'd0);
    end else begin
      check("R1 strobe", {31'd0, wrStrobe}, 32'd1);
      check("R2 format", {31'd0, srcIsImm}, {31'd0, ~w[15]});
      check("R4 dst module", {28'd0, dstModule}, {28'd0, w[11:8]});
      check("R4 dst index", {27'd0, dstIndex}, {27'd0, (mPend ? mHi : 2'b00), w[14:12]});
      if (w[15]) begin
        check("R3 src module", {28'd0, srcModule}, {28'd0, w[3:0]});
        check("R3 src index", {28'd0, srcIndex}, {28'd0, w[7:4]});
        check("R2 no imm on reg", {16'd0, immValue}, 32'd0);
      end else begin
        expImm = {((mPend && mEn) ? mByte : 8'h00), w[7:0]};
        check("R7 immediate", {16'd0, immValue}, {16'd0, expImm});
        check("R2 no src on imm", {24'd0, srcModule, srcIndex}, 32'd0);
      end
    end
    if (v) begin
      if (isP) begin
        mPend = 1'b1; mHi = w[13:12]; mEn = w[14]; mByte = w[7:0];
      end else begin
        mPend = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", {31'd0, wrStrobe}, 32'd0);
    rst = 1'b0;
    // Exhaustive sweep of every word, reference prefix state tracked.
    for (int i = 0; i < 65536; i++) begin
      step(1'b1, i[15:0]);
      if (i % 4099 == 0) step(1'b0, 16'hFFFF);
    end
    // Every prefix setting against varied followers, with idle gaps (R6).
    for (int s = 0; s < 8; s++) begin
      for (int b = 0; b < 4; b++) begin
        for (int t = 0; t < 32; t++) begin
          logic [7:0] pb;
          logic [15:0] f;
          pb = (b == 0) ? 8'h00 : (b == 1) ? 8'h5A : (b == 2) ? 8'hFF : 8'h81;
          f = 16'(t * 2741 + s * 97 + b);
          if (f[11:8] == PFX) f[8] = ~f[8];
          step(1'b1, {1'b0, s[2:0], PFX, pb});
          if (t % 3 == 0) step(1'b0, 16'h0000);
          step(1'b1, f);
          step(1'b1, f ^ 16'h8001);
        end
      end
    end
    // R6: newer prefix replaces older
    step(1'b1, {1'b1, 3'b111, PFX, 8'h12});
    step(1'b1, {1'b0, 3'b001, PFX, 8'h34});
    step(1'b1, 16'h3A55);
    check("R6 replaced prefix", {27'd0, dstIndex}, {27'd0, 5'b01011});
    // R8: reset drops a pending prefix
    step(1'b1, {1'b1, 3'b111, PFX, 8'hEE});
    rst = 1'b1;
    instrValid = 1'b1; instr = 16'h7222;
    @(negedge clk);
    check("R8 strobe low in reset", {31'd0, wrStrobe}, 32'd0);
    rst = 1'b0;
    mPend = 1'b0;
    step(1'b1, 16'h7244);
    check("R8 prefix cleared", {27'd0, dstIndex}, {27'd0, 5'b00111});
    check("R8 imm no byte", {16'd0, immValue}, 32'h0044);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule